// File: doc/BRIEF.md
# Serial Clock Routing Multiplexer

This block routes clock-enable strobes to six serial channels. Four of them are full-duplex and carry separate receive and transmit selects. Two are simple channels with one shared select each. Every select is a 3-bit code. Codes 0 to 3 pick one of four baud generator strobes. Codes 4 to 7 pick one of four external clock-pin strobes. Channels are split into two banks, and each bank sees a different group of four external pins. All inputs are single-cycle enables in the same clock domain as the block. The block does no real clock switching.

Two 32-bit select registers hold the codes. Software updates them with a data word and a bit mask, so one field can be changed in a single write without disturbing its neighbours. A registered read port returns either register. Every channel output is registered.

Top module: `clk_route_matrix`

## Requirements
- R1: Reset (synchronous, active high) clears both select registers and rd_data to zero. After reset every channel output follows gen_en[0].
- R2: A write with wr_en high changes only the bits of the addressed register whose wr_mask bit is 1; those bits take wr_data. All other bits keep their value.
- R3: wr_addr 0 addresses the duplex register and wr_addr 1 the simple register. A write never changes the register it does not address. Bits outside the select fields store and read back exactly as written.
- R4: rd_data presents the register chosen by rd_addr (0 duplex, 1 simple) one clock after rd_addr is applied, and shows a write one clock after the write edge.
- R5: Select codes 0, 1, 2, 3 route gen_en[0], gen_en[1], gen_en[2], gen_en[3] respectively.
- R6: For duplex channels 0 and 1 and simple channel 0, codes 4 to 7 route ext_en[0] to ext_en[3].
- R7: For duplex channels 2 and 3 and simple channel 1, codes 4 to 7 route ext_en[4] to ext_en[7].
- R8: Duplex channel i takes its transmit code from duplex-register bits [8i+2:8i] and its receive code from bits [8i+5:8i+3]. The two codes act independently.
- R9: Simple channel 0 takes its code from simple-register bits [14:12] and simple channel 1 from bits [30:28].
- R10: Each channel output is registered. It shows the routed strobe of the previous clock, and a select write takes effect at the output one clock after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = duplex register, 1 = simple register |
| wr_data | input | 32 | Write data |
| wr_mask | input | 32 | Per-bit write enable |
| rd_addr | input | 1 | Register chosen for readback |
| rd_data | output | 32 | Registered readback |
| gen_en | input | 4 | Baud generator strobes |
| ext_en | input | 8 | External clock-pin strobes |
| dx_tx_en | output | 4 | Routed transmit strobe per duplex channel |
| dx_rx_en | output | 4 | Routed receive strobe per duplex channel |
| sp_en | output | 2 | Routed strobe per simple channel |

## Verification
The bench sweeps every code through every field while it walks a single active strobe across all twelve inputs. This catches a design that swaps the two external-pin banks or offsets a code by one; either fault routes the wrong pin. Receive and transmit codes in each lane are set differently, and the two simple channels get mirrored codes, so a wrong field offset or swapped receive and transmit fields shows up as a mismatch. Masked writes that touch only part of a field, and writes to the other register, expose read-modify-write errors that would clobber neighbouring bits. A latency check shows whether an output is combinational instead of registered.

// File: rtl/clk_route_pkg.sv
package clk_route_pkg;
  localparam int REG_W        = 32;
  localparam int SEL_W        = 3;
  localparam int N_GEN        = 4;
  localparam int EXT_PER_BANK = 4;
  localparam int N_BANK       = 2;
  localparam int N_EXT        = EXT_PER_BANK * N_BANK;
  localparam int N_DUPLEX     = 4;
  localparam int N_SIMPLE     = 2;
  localparam int LANE_W       = 8;
  localparam int RX_OFS       = 3;
  localparam int SP_BASE      = 12;
  localparam int SP_STEP      = 16;

  typedef logic [SEL_W-1:0] sel_t;

  function automatic int dx_tx_lsb(input int ch);
    return ch * LANE_W;
  endfunction

  function automatic int dx_rx_lsb(input int ch);
    return ch * LANE_W + RX_OFS;
  endfunction

  function automatic int sp_lsb(input int ch);
    return SP_BASE + ch * SP_STEP;
  endfunction

  // duplex 0,1 -> bank 0 ; duplex 2,3 -> bank 1
  function automatic int dx_bank(input int ch);
    return ch / (N_DUPLEX / N_BANK);
  endfunction

  function automatic int sp_bank(input int ch);
    return ch;
  endfunction
endpackage

// File: rtl/clk_sel_regs.sv
module clk_sel_regs
  import clk_route_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [REG_W-1:0] wr_mask,
  input  logic             rd_addr,
  output logic [REG_W-1:0] rd_data,
  output logic [REG_W-1:0] dx_q,
  output logic [REG_W-1:0] sp_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dx_q    <= '0;
      sp_q    <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en && !wr_addr) dx_q <= (dx_q & ~wr_mask) | (wr_data & wr_mask);
      if (wr_en &&  wr_addr) sp_q <= (sp_q & ~wr_mask) | (wr_data & wr_mask);
      rd_data <= rd_addr ? sp_q : dx_q;
    end
  end

  // R2
  dx_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr) |=> (((dx_q ^ $past(dx_q)) & ~$past(wr_mask)) == '0)
                         && ((dx_q & $past(wr_mask)) == ($past(wr_data) & $past(wr_mask))));
  // R2
  sp_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr) |=> (((sp_q ^ $past(sp_q)) & ~$past(wr_mask)) == '0)
                        && ((sp_q & $past(wr_mask)) == ($past(wr_data) & $past(wr_mask))));
  // R3
  other_reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ($past(wr_addr) ? $stable(dx_q) : $stable(sp_q)));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(dx_q) && $stable(sp_q)));
endmodule

// File: rtl/clk_src_pick.sv
module clk_src_pick
  import clk_route_pkg::*;
#(
  parameter int BANK = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  sel_t             code,
  input  logic [N_GEN-1:0] gen_en,
  input  logic [N_EXT-1:0] ext_en,
  output logic             q
);
  localparam int GEN_IW = $clog2(N_GEN);
  localparam int EXT_IW = $clog2(N_EXT);

  logic              use_ext;
  logic [GEN_IW-1:0] gen_idx;
  logic [EXT_IW-1:0] ext_idx;
  logic              pick;

  always_comb begin
    use_ext = (int'(code) >= N_GEN);
    gen_idx = code[GEN_IW-1:0];
    ext_idx = EXT_IW'(BANK * EXT_PER_BANK + (int'(code) - N_GEN));
    pick    = use_ext ? ext_en[ext_idx] : gen_en[gen_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= pick;
  end

  // R5
  gen_route_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(code) < N_GEN) |=> (q == $past(gen_en[code[GEN_IW-1:0]])));
  // R6
  ext_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(code) >= N_GEN) |=> (q == $past(ext_en[BANK*EXT_PER_BANK + int'(code) - N_GEN])));
endmodule

// File: rtl/clk_route_matrix.sv
module clk_route_matrix
  import clk_route_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                wr_addr,
  input  logic [REG_W-1:0]    wr_data,
  input  logic [REG_W-1:0]    wr_mask,
  input  logic                rd_addr,
  output logic [REG_W-1:0]    rd_data,
  input  logic [N_GEN-1:0]    gen_en,
  input  logic [N_EXT-1:0]    ext_en,
  output logic [N_DUPLEX-1:0] dx_tx_en,
  output logic [N_DUPLEX-1:0] dx_rx_en,
  output logic [N_SIMPLE-1:0] sp_en
);
  logic [REG_W-1:0] dx_q;
  logic [REG_W-1:0] sp_q;

  clk_sel_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_mask(wr_mask), .rd_addr(rd_addr),
    .rd_data(rd_data), .dx_q(dx_q), .sp_q(sp_q)
  );

  // R8: per-lane transmit and receive pickers
  for (genvar i = 0; i < N_DUPLEX; i++) begin : g_dx
    clk_src_pick #(.BANK(dx_bank(i))) u_tx (
      .clk(clk), .rst(rst), .code(dx_q[dx_tx_lsb(i) +: SEL_W]),
      .gen_en(gen_en), .ext_en(ext_en), .q(dx_tx_en[i])
    );
    clk_src_pick #(.BANK(dx_bank(i))) u_rx (
      .clk(clk), .rst(rst), .code(dx_q[dx_rx_lsb(i) +: SEL_W]),
      .gen_en(gen_en), .ext_en(ext_en), .q(dx_rx_en[i])
    );
  end

  // R9: simple channel pickers
  for (genvar j = 0; j < N_SIMPLE; j++) begin : g_sp
    clk_src_pick #(.BANK(sp_bank(j))) u_sp (
      .clk(clk), .rst(rst), .code(sp_q[sp_lsb(j) +: SEL_W]),
      .gen_en(gen_en), .ext_en(ext_en), .q(sp_en[j])
    );
  end

  // R4
  readback_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rd_data == ($past(rd_addr) ? $past(sp_q) : $past(dx_q))));
endmodule

// File: tb/clk_route_matrix_test.sv
module clk_route_matrix_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [31:0] wr_data = '0, wr_mask = '0;
  logic [31:0] rd_data;
  logic [3:0]  gen_en = '0;
  logic [7:0]  ext_en = '0;
  logic [3:0]  dx_tx_en, dx_rx_en;
  logic [1:0]  sp_en;

  int checks = 0;
  int fails  = 0;
  logic [31:0] m_dx = '0, m_sp = '0;

  always #4 clk = ~clk;

  clk_route_matrix uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_mask(wr_mask), .rd_addr(rd_addr),
    .rd_data(rd_data), .gen_en(gen_en), .ext_en(ext_en),
    .dx_tx_en(dx_tx_en), .dx_rx_en(dx_rx_en), .sp_en(sp_en)
  );

  function automatic logic route(input logic [2:0] c, input int bank,
                                 input logic [3:0] g, input logic [7:0] e);
    if (c < 3'd4) return g[c[1:0]];
    return e[bank*4 + int'(c) - 4];
  endfunction

  // packed as {sp[1:0], rx[3:0], tx[3:0]}
  function automatic logic [9:0] expect_out(input logic [3:0] g, input logic [7:0] e);
    logic [9:0] r;
    for (int i = 0; i < 4; i++) begin
      r[i]   = route(m_dx[8*i +: 3], i/2, g, e);
      r[4+i] = route(m_dx[8*i+3 +: 3], i/2, g, e);
    end
    for (int j = 0; j < 2; j++) r[8+j] = route(m_sp[12+16*j +: 3], j, g, e);
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic a, input logic [31:0] d, input logic [31:0] m);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_mask = m;
    @(negedge clk);
    wr_en = 1'b0; wr_mask = '0;
    if (a) m_sp = (m_sp & ~m) | (d & m);
    else   m_dx = (m_dx & ~m) | (d & m);
  endtask

  task automatic read_chk(input logic a, input string tag);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    check(tag, rd_data, a ? m_sp : m_dx);
  endtask

  task automatic out_chk(input logic [3:0] g, input logic [7:0] e, input string tag);
    @(negedge clk);
    gen_en = g; ext_en = e;
    @(negedge clk);
    check(tag, {22'd0, sp_en, dx_rx_en, dx_tx_en}, {22'd0, expect_out(g, e)});
  endtask

  task automatic t_reset;
    check("R1 rd_data after reset", rd_data, 32'h0);
    read_chk(1'b1, "R1 simple reg zero");
    read_chk(1'b0, "R1 duplex reg zero");
    out_chk(4'b0001, 8'h00, "R1 all follow gen0 high");
    out_chk(4'b1110, 8'hFF, "R1 all follow gen0 low");
  endtask

  task automatic t_masked;
    write_reg(1'b0, 32'hFFFF_FFFF, 32'h0000_FFFF);
    read_chk(1'b0, "R2 low half set");
    write_reg(1'b0, 32'h0000_0000, 32'h0000_00F0);
    read_chk(1'b0, "R2 partial clear");
    check("R2 literal value", rd_data, 32'h0000_FF0F);
    write_reg(1'b0, 32'hA5A5_A5A5, 32'h0000_0000);
    read_chk(1'b0, "R2 zero mask no change");
  endtask

  task automatic t_cross;
    logic [31:0] dx_before;
    dx_before = m_dx;
    write_reg(1'b1, 32'h8C3F_4E21, 32'hFFFF_FFFF);
    read_chk(1'b1, "R3 simple reg readback incl unused bits");
    read_chk(1'b0, "R3 duplex untouched");
    check("R3 duplex literal", rd_data, dx_before);
    write_reg(1'b0, 32'hC0C0_C0C0, 32'hC0C0_C0C0);
    read_chk(1'b0, "R3 unused duplex bits store");
    read_chk(1'b1, "R3 simple untouched");
  endtask

  task automatic t_readlat;
    @(negedge clk);
    rd_addr = 1'b0;
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = 32'h1234_5678; wr_mask = 32'hFFFF_FFFF;
    @(negedge clk);
    wr_en = 1'b0; wr_mask = '0;
    check("R4 old value before write visible", rd_data, m_dx);
    m_dx = 32'h1234_5678;
    @(negedge clk);
    check("R4 new value one clock later", rd_data, m_dx);
  endtask

  task automatic t_sweep;
    for (int c = 0; c < 8; c++) begin
      logic [31:0] d, s;
      d = '0; s = '0;
      for (int i = 0; i < 4; i++) begin
        d[8*i +: 3]   = 3'(c);
        d[8*i+3 +: 3] = 3'((c + 3 + i) % 8);
      end
      s[14:12] = 3'(c);
      s[30:28] = 3'(7 - c);
      write_reg(1'b0, d, 32'hFFFF_FFFF);
      write_reg(1'b1, s, 32'hFFFF_FFFF);
      for (int b = 0; b < 12; b++) begin
        logic [11:0] oh;
        oh = 12'd1 << b;
        out_chk(oh[3:0], oh[11:4],
                c < 4 ? "R5 R8 R9 generator codes" : "R6 R7 R8 R9 external banks");
      end
      out_chk(4'hF, 8'hFF, "R5 all high");
    end
  endtask

  task automatic t_latency;
    write_reg(1'b0, 32'h0, 32'hFFFF_FFFF);
    write_reg(1'b1, 32'h0, 32'hFFFF_FFFF);
    out_chk(4'b0001, 8'h00, "R10 settle high");
    @(negedge clk);
    gen_en = 4'b0000;
    #1;
    check("R10 output holds until next edge", {28'd0, dx_tx_en}, 32'hF);
    @(negedge clk);
    check("R10 output drops after edge", {28'd0, dx_tx_en}, 32'h0);
    // select change reaches output one clock after write edge
    ext_en = 8'h01; gen_en = 4'b0000;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = 32'h0000_0004; wr_mask = 32'h0000_0007;
    @(negedge clk);
    wr_en = 1'b0; wr_mask = '0;
    check("R10 old select still at output", {31'd0, dx_tx_en[0]}, 32'h0);
    @(negedge clk);
    check("R10 new select at output", {31'd0, dx_tx_en[0]}, 32'h1);
    m_dx = 32'h0000_0004;
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_masked;
    t_cross;
    t_readlat;
    t_sweep;
    t_latency;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule